// File: doc/BRIEF.md
# DMA Transfer Bus-Cycle Sequencer

This block carries out a single DMA transfer as a read phase followed by a write phase. Each phase is split into one or two bus accesses. The split depends on the transfer unit (byte or word), the parity of the address, and the width of the bus behind that address. Every access holds its strobe for a number of clocks set by the memory region of its address. An optional recovery clock can be added to each access.

The source and destination are handled independently. Each has its own region code and its own address parity, and any combination of the two is legal. Read data is collected in a 16-bit holding buffer and written back out unchanged. A one-clock completion pulse follows the final write access. The block expects arbitration, address stepping and transfer counting to be handled outside it. The start request carries a full snapshot of the transfer parameters.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `rd_o`, `wr_o` and `done_o` are all 0.
- R2: A `start_i` sampled while idle latches every configuration input and begins a transfer. A `start_i` sampled while busy is ignored, and the running transfer completes with its original parameters.
- R3: All read accesses finish before the first write access. `rd_o` and `wr_o` are never both 1. `done_o` is 1 for exactly one clock, the clock right after the last `wr_o` clock, and `busy_o` is 0 on the following clock.
- R4: With `unit16_i`=0 each phase makes exactly one access, whatever the address parity or bus width.
- R5: With `unit16_i`=1 on a 16-bit bus, an even address takes one word access with `lane_o`=2'b11 (low byte on bits 7:0, high byte on bits 15:8). An odd address takes two byte accesses.
- R6: A region is on an 8-bit bus only when its code is 3 (external) and `bus16_i`=0. Regions 0 to 2 are always 16-bit. On an 8-bit bus a word takes two accesses, and every access uses `lane_o`=2'b01 with its data on bits 7:0.
- R7: On a 16-bit bus a byte access at an even address uses `lane_o`=2'b01 with data on bits 7:0. A byte access at an odd address uses `lane_o`=2'b10 with data on bits 15:8.
- R8: A word split into two accesses transfers its low byte at the given address first, then its high byte at address+1. The source and destination parities are independent.
- R9: The bytes written at the destination address and at destination+1 equal the bytes read from the source address and from source+1.
- R10: The clocks per access are set by the region code: code 0 gives 1, code 1 gives 2, code 2 gives 2, and code 3 gives `ext_wait_i` clamped into the range 2 to 9.
- R11: With `recov_en_i`=1 every access lasts one clock longer than its region value.
- R12: The `rd_o` clocks total the number of read accesses times the source multiplier. The `wr_o` clocks total the number of write accesses times the destination multiplier. `addr_o` and `lane_o` stay constant for the whole of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (accepted only when idle) |
| src_addr_i | input | AW | Source address |
| dst_addr_i | input | AW | Destination address |
| unit16_i | input | 1 | 1 = word transfer, 0 = byte transfer |
| bus16_i | input | 1 | External bus width, 1 = 16-bit |
| src_rgn_i | input | 2 | Source region: 0 fast RAM, 1 waited RAM, 2 register area, 3 external |
| dst_rgn_i | input | 2 | Destination region, same coding |
| ext_wait_i | input | WAIT_W | External clocks per access (clamped 2..9) |
| recov_en_i | input | 1 | Add one recovery clock per access |
| rd_data_i | input | 16 | Read data bus |
| busy_o | output | 1 | Transfer in progress |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | AW | Access address |
| lane_o | output | 2 | Active byte lanes (bit0 = bits 7:0, bit1 = bits 15:8) |
| wr_data_o | output | 16 | Write data |
| done_o | output | 1 | One-clock completion pulse |

## Verification
Two events can land in the same clock. One is a new `start_i` arriving while a transfer is still busy. The other is the end of an access, where the phase advances, the holding buffer is loaded and the access index steps. The bench pulses `start_i` with a different source address on the second busy clock of every transfer. It then judges the outcome from the destination bytes, the strobe counts and the single `done_o` pulse, all of which must match the original request. The sweep also covers every combination of source and destination parity and region. This makes the last read access, which captures into the buffer, hand over directly to a first write access that may sit in any lane.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    RGN_RAM_FAST = 2'd0,
    RGN_RAM_SLOW = 2'd1,
    RGN_REGS     = 2'd2,
    RGN_EXT      = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } seq_state_e;

  localparam int unsigned EXT_WAIT_MIN = 2;
  localparam int unsigned EXT_WAIT_MAX = 9;
  localparam int unsigned FAST_MULT    = 1;
  localparam int unsigned SLOW_MULT    = 2;

  localparam logic [1:0] LANE_LO   = 2'b01;
  localparam logic [1:0] LANE_HI   = 2'b10;
  localparam logic [1:0] LANE_BOTH = 2'b11;

endpackage

// File: rtl/dma_phase_cost.sv
module dma_phase_cost
  import dma_xfer_pkg::*;
#(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned MULT_W = 4
) (
  input  logic [1:0]        region_i,
  input  logic              addr_lsb_i,
  input  logic              unit16_i,
  input  logic              bus16_i,
  input  logic [WAIT_W-1:0] ext_wait_i,
  input  logic              recov_en_i,
  output logic [MULT_W-1:0] mult_o,
  output logic              two_acc_o,
  output logic              word_acc_o,
  output logic              bus8_o
);

  logic [MULT_W-1:0] base_mult;
  logic [MULT_W-1:0] ext_mult;

  always_comb begin
    if (32'(ext_wait_i) < EXT_WAIT_MIN)      ext_mult = MULT_W'(EXT_WAIT_MIN);
    else if (32'(ext_wait_i) > EXT_WAIT_MAX) ext_mult = MULT_W'(EXT_WAIT_MAX);
    else                                     ext_mult = MULT_W'(ext_wait_i);
  end

  always_comb begin
    unique case (region_e'(region_i))
      RGN_RAM_FAST: base_mult = MULT_W'(FAST_MULT);
      RGN_RAM_SLOW: base_mult = MULT_W'(SLOW_MULT);
      RGN_REGS:     base_mult = MULT_W'(SLOW_MULT);
      default:      base_mult = ext_mult;
    endcase
  end

  assign mult_o     = base_mult + MULT_W'(recov_en_i);
  // only external space can be narrow
  assign bus8_o     = (region_e'(region_i) == RGN_EXT) && !bus16_i;
  assign two_acc_o  = unit16_i && (bus8_o || addr_lsb_i);
  assign word_acc_o = unit16_i && !two_acc_o;

endmodule

// File: rtl/dma_lane_sel.sv
module dma_lane_sel
  import dma_xfer_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic          idx_i,
  input  logic          bus8_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    lane_o
);

  assign addr_o = base_i + AW'(idx_i);

  always_comb begin
    if (word_i)         lane_o = LANE_BOTH;
    else if (bus8_i)    lane_o = LANE_LO;
    else if (addr_o[0]) lane_o = LANE_HI;
    else                lane_o = LANE_LO;
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic              unit16_i,
  input  logic              bus16_i,
  input  logic [1:0]        src_rgn_i,
  input  logic [1:0]        dst_rgn_i,
  input  logic [WAIT_W-1:0] ext_wait_i,
  input  logic              recov_en_i,
  input  logic [15:0]       rd_data_i,
  output logic              busy_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        lane_o,
  output logic [15:0]       wr_data_o,
  output logic              done_o
);

  localparam int unsigned MULT_W = $clog2(EXT_WAIT_MAX + 2);
  localparam int unsigned NPH    = 2;

  seq_state_e        state_q;
  logic              idx_q;
  logic [MULT_W-1:0] cnt_q;
  logic [15:0]       buf_q;

  logic [AW-1:0]     src_q, dst_q;
  logic [1:0]        src_rgn_q, dst_rgn_q;
  logic              unit16_q, bus16_q, recov_q;
  logic [WAIT_W-1:0] ext_wait_q;

  logic [AW-1:0]     base_a  [NPH];
  logic [1:0]        rgn_a   [NPH];
  logic [MULT_W-1:0] mult_a  [NPH];
  logic              two_a   [NPH];
  logic              word_a  [NPH];
  logic              bus8_a  [NPH];

  assign base_a[0] = src_q;
  assign base_a[1] = dst_q;
  assign rgn_a[0]  = src_rgn_q;
  assign rgn_a[1]  = dst_rgn_q;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    dma_phase_cost #(
      .WAIT_W (WAIT_W),
      .MULT_W (MULT_W)
    ) u_cost (
      .region_i   (rgn_a[p]),
      .addr_lsb_i (base_a[p][0]),
      .unit16_i   (unit16_q),
      .bus16_i    (bus16_q),
      .ext_wait_i (ext_wait_q),
      .recov_en_i (recov_q),
      .mult_o     (mult_a[p]),
      .two_acc_o  (two_a[p]),
      .word_acc_o (word_a[p]),
      .bus8_o     (bus8_a[p])
    );
  end

  logic              ph;
  logic              strobe;
  logic [MULT_W-1:0] mult_cur;
  logic              acc_last;
  logic              phase_last;
  logic [AW-1:0]     acc_addr;
  logic [1:0]        acc_lane;
  logic [7:0]        rd_byte;
  logic [7:0]        wr_byte;

  assign ph         = (state_q == ST_WRITE);
  assign strobe     = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mult_cur   = mult_a[ph];
  assign acc_last   = (cnt_q == MULT_W'(mult_cur - 1'b1));
  assign phase_last = acc_last && (idx_q == two_a[ph]);

  dma_lane_sel #(
    .AW (AW)
  ) u_lane (
    .base_i (base_a[ph]),
    .idx_i  (idx_q),
    .bus8_i (bus8_a[ph]),
    .word_i (word_a[ph]),
    .addr_o (acc_addr),
    .lane_o (acc_lane)
  );

  assign rd_byte = (acc_lane == LANE_HI) ? rd_data_i[15:8] : rd_data_i[7:0];
  assign wr_byte = idx_q ? buf_q[15:8] : buf_q[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= 1'b0;
      cnt_q      <= '0;
      buf_q      <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      src_rgn_q  <= '0;
      dst_rgn_q  <= '0;
      unit16_q   <= 1'b0;
      bus16_q    <= 1'b0;
      recov_q    <= 1'b0;
      ext_wait_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            src_q      <= src_addr_i;
            dst_q      <= dst_addr_i;
            src_rgn_q  <= src_rgn_i;
            dst_rgn_q  <= dst_rgn_i;
            unit16_q   <= unit16_i;
            bus16_q    <= bus16_i;
            recov_q    <= recov_en_i;
            ext_wait_q <= ext_wait_i;
            idx_q      <= 1'b0;
            cnt_q      <= '0;
            state_q    <= ST_READ;
          end
        end
        ST_READ: begin
          if (acc_last) begin
            cnt_q <= '0;
            if (word_a[0])   buf_q        <= rd_data_i;
            else if (!idx_q) buf_q[7:0]   <= rd_byte;
            else             buf_q[15:8]  <= rd_byte;
            if (phase_last) begin
              idx_q   <= 1'b0;
              state_q <= ST_WRITE;
            end else begin
              idx_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WRITE: begin
          if (acc_last) begin
            cnt_q <= '0;
            if (phase_last) begin
              idx_q   <= 1'b0;
              state_q <= ST_DONE;
            end else begin
              idx_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rd_o      = (state_q == ST_READ);
  assign wr_o      = (state_q == ST_WRITE);
  assign done_o    = (state_q == ST_DONE);
  assign addr_o    = strobe ? acc_addr : '0;
  assign lane_o    = strobe ? acc_lane : 2'b00;
  assign wr_data_o = !wr_o ? 16'h0000 : (word_a[1] ? buf_q : {wr_byte, wr_byte});

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R3
  done_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_o));

  // R12
  access_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && cnt_q != '0) |-> ($stable(addr_o) && $stable(lane_o)));

  // R2
  start_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(unit16_q)));

  // R3
  no_read_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !rd_o);

endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int WAIT_W     = 4;
  localparam int WATCHDOG   = 190000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start;
  logic [AW-1:0]     src_addr, dst_addr;
  logic              unit16, bus16, recov;
  logic [1:0]        src_rgn, dst_rgn;
  logic [WAIT_W-1:0] ext_wait;
  logic [15:0]       rd_data;
  logic              busy, rd, wr, done;
  logic [AW-1:0]     addr;
  logic [1:0]        lane;
  logic [15:0]       wr_data;

  logic              src_bus8_m;

  int n_vec  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit summary_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_seq #(.AW(AW), .WAIT_W(WAIT_W)) u_dma_xfer_seq (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .src_addr_i (src_addr),
    .dst_addr_i (dst_addr),
    .unit16_i   (unit16),
    .bus16_i    (bus16),
    .src_rgn_i  (src_rgn),
    .dst_rgn_i  (dst_rgn),
    .ext_wait_i (ext_wait),
    .recov_en_i (recov),
    .rd_data_i  (rd_data),
    .busy_o     (busy),
    .rd_o       (rd),
    .wr_o       (wr),
    .addr_o     (addr),
    .lane_o     (lane),
    .wr_data_o  (wr_data),
    .done_o     (done)
  );

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: narrow bus returns the addressed byte on bits 7:0
  always_comb begin
    if (!rd)             rd_data = 16'hDEAD;
    else if (src_bus8_m) rd_data = {8'h00, mem_byte(addr)};
    else                 rd_data = {mem_byte(addr | 16'h1), mem_byte(addr & ~16'h1)};
  end

  function automatic int exp_mult(int rg, int ew, bit rc);
    int m;
    if (rg == 0)      m = 1;
    else if (rg < 3)  m = 2;
    else if (ew < 2)  m = 2;
    else if (ew > 9)  m = 9;
    else              m = ew;
    return m + int'(rc);
  endfunction

  function automatic int exp_nacc(bit u16, bit b16, int rg, bit odd);
    bit narrow;
    narrow = (rg == 3) && !b16;
    if (!u16) return 1;
    return (narrow || odd) ? 2 : 1;
  endfunction

  task automatic report();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      report();
    end
  end

  function automatic string acc_tag(bit u16, bit narrow);
    if (!u16)   return "R4";
    if (narrow) return "R6";
    return "R5";
  endfunction

  task automatic run_xfer(bit u16, bit b16, int sr, int dr, bit sp, bit dp,
                          bit rc, int ew, int n);
    logic [AW-1:0] s_a, d_a, prev_addr;
    int  rd_cyc, wr_cyc, rd_acc, wr_acc, k, done_k, last_wr_k;
    bit  rd_after_wr, lane_bad, first_bad, got0, got1, prev_strobe;
    bit  s_narrow, d_narrow, d_word, s_word;
    logic [7:0] b0, b1;
    int  js, kd, ns, nd;

    s_a = AW'(16'h2000 + n * 8) | AW'(sp);
    d_a = AW'(16'h8000 + n * 8) | AW'(dp);
    s_narrow = (sr == 3) && !b16;
    d_narrow = (dr == 3) && !b16;
    s_word = u16 && !s_narrow && !sp;
    d_word = u16 && !d_narrow && !dp;
    js = exp_mult(sr, ew, rc);
    kd = exp_mult(dr, ew, rc);
    ns = exp_nacc(u16, b16, sr, sp);
    nd = exp_nacc(u16, b16, dr, dp);

    @(negedge clk);
    src_addr = s_a; dst_addr = d_a; unit16 = u16; bus16 = b16;
    src_rgn = 2'(sr); dst_rgn = 2'(dr); ext_wait = WAIT_W'(ew); recov = rc;
    src_bus8_m = s_narrow;
    start = 1'b1;

    rd_cyc = 0; wr_cyc = 0; rd_acc = 0; wr_acc = 0; done_k = 0; last_wr_k = 0;
    rd_after_wr = 0; lane_bad = 0; first_bad = 0; got0 = 0; got1 = 0;
    prev_strobe = 0; prev_addr = '0; b0 = 8'h00; b1 = 8'h00;

    for (k = 1; k < 100 && done_k == 0; k++) begin
      @(negedge clk);
      if (rd || wr) begin
        bit narrow, word;
        narrow = rd ? s_narrow : d_narrow;
        word   = rd ? s_word : d_word;
        if (!prev_strobe || addr != prev_addr) begin
          if (rd) begin
            if (rd_acc == 0 && addr != s_a) first_bad = 1;
            rd_acc++;
          end else begin
            if (wr_acc == 0 && addr != d_a) first_bad = 1;
            wr_acc++;
          end
        end
        if (narrow)      lane_bad |= (lane != 2'b01);
        else if (word)   lane_bad |= (lane != 2'b11) || addr[0];
        else             lane_bad |= (lane != (addr[0] ? 2'b10 : 2'b01));
      end
      if (rd) begin
        rd_cyc++;
        if (wr_cyc != 0) rd_after_wr = 1;
      end
      if (wr) begin
        wr_cyc++;
        last_wr_k = k;
        if (lane == 2'b11) begin
          if (addr == d_a) begin b0 = wr_data[7:0]; b1 = wr_data[15:8]; got0 = 1; got1 = 1; end
          else lane_bad = 1;
        end else begin
          logic [7:0] wb;
          wb = (lane == 2'b10) ? wr_data[15:8] : wr_data[7:0];
          if (addr == d_a)                 begin b0 = wb; got0 = 1; end
          else if (addr == d_a + AW'(1))   begin b1 = wb; got1 = 1; end
          else lane_bad = 1;
        end
      end
      if (rd && wr) rd_after_wr = 1;
      if (done) done_k = k;
      prev_strobe = rd || wr;
      prev_addr   = addr;
      // busy-time start with altered parameters must be ignored
      if (k == 1) start = 1'b0;
      if (k == 2) begin start = 1'b1; src_addr = s_a ^ 16'h0F0E; unit16 = ~u16; end
      if (k == 3) begin start = 1'b0; src_addr = s_a; unit16 = u16; end
    end
    start = 1'b0; src_addr = s_a; unit16 = u16;

    chk(done_k != 0 && done_k == last_wr_k + 1, "R3 done follows last write", done_k, last_wr_k + 1);
    chk(!rd_after_wr, "R3 read phase precedes write phase", int'(rd_after_wr), 0);
    chk(rd_acc == ns, acc_tag(u16, s_narrow), rd_acc, ns);
    chk(wr_acc == nd, acc_tag(u16, d_narrow), wr_acc, nd);
    chk(rd_cyc == ns * js, rc ? "R11 R12 read clocks" : "R10 R12 read clocks", rd_cyc, ns * js);
    chk(wr_cyc == nd * kd, rc ? "R11 R12 write clocks" : "R10 R12 write clocks", wr_cyc, nd * kd);
    chk(!lane_bad, "R7 lane/address legality", int'(lane_bad), 0);
    chk(!first_bad, "R8 low byte at base address first", int'(first_bad), 0);
    chk(got0 && b0 == mem_byte(s_a), "R9 byte at destination", int'(b0), int'(mem_byte(s_a)));
    if (u16)
      chk(got1 && b1 == mem_byte(s_a + AW'(1)), "R8 R9 high byte at destination+1",
          int'(b1), int'(mem_byte(s_a + AW'(1))));
    @(negedge clk);
    chk(!busy && !done, "R2 R3 idle after done, busy start ignored", int'(busy), 0);
  endtask

  initial begin
    int n;
    int ew_tab [4] = '{1, 4, 9, 12};
    start = 0; src_addr = '0; dst_addr = '0; unit16 = 0; bus16 = 0; recov = 0;
    src_rgn = '0; dst_rgn = '0; ext_wait = '0; src_bus8_m = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd && !wr && !done, "R1 reset idle", int'({busy, rd, wr, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd && !wr && !done, "R1 idle after release", int'({busy, rd, wr, done}), 0);
    n = 0;
    for (int u = 0; u < 2; u++)
      for (int b = 0; b < 2; b++)
        for (int sr = 0; sr < 4; sr++)
          for (int dr = 0; dr < 4; dr++)
            for (int sp = 0; sp < 2; sp++)
              for (int dp = 0; dp < 2; dp++)
                for (int rc = 0; rc < 2; rc++)
                  for (int e = 0; e < 4; e++) begin
                    run_xfer(bit'(u), bit'(b), sr, dr, bit'(sp), bit'(dp), bit'(rc), ew_tab[e], n);
                    n++;
                  end
    report();
  end

endmodule